// File: doc/BRIEF.md
# I2C Register Slave with Auto-Increment Pointer

This block lets a host microcontroller read and write a bank of 8-bit registers over a two-wire I2C bus. The clock and data lines are brought into the system clock domain through a short synchronizer. START and STOP conditions and SCL edges are taken from the synchronized samples. A fixed 7-bit device address selects the slave. The system clock must run at least eight times faster than SCL. The slave drives SDA only by pulling it low: `sda_oe` high means the pad pulls the line to ground.

A write transfer carries one sub-address byte and then any number of data bytes. A read transfer returns bytes until the master withholds its acknowledge. Writes and reads share one byte pointer. The sub-address byte loads the pointer, and every byte written or read advances it by one, wrapping at the top of the address space. A read that is not preceded by a sub-address therefore continues from wherever the last access left the pointer. A random read is a write of the sub-address alone, followed by a repeated START and a read.

The register file sits outside the block and is reached through a plain strobe port. `reg_addr` always shows the pointer. A one-cycle `reg_wr_en` presents `reg_wdata` for the register at `reg_addr`, and a one-cycle `reg_rd_en` marks the cycle in which `reg_rdata` is captured. The register file must accept a write and return read data within that same cycle. There is no back-pressure: the bus timing leaves no room for a stall, because clock stretching is not used.

Top module: `i2c_reg_slave`

## Requirements
- R1: The slave acknowledges a first byte only when its upper seven bits equal binary 1000011. Bit 0 of that byte selects the direction: 1 is read, 0 is write. After any other address the slave leaves SDA released, writes nothing and keeps its pointer until the next START.
- R2: A START (SDA falling while SCL is high) restarts address reception from any state. A STOP (SDA rising while SCL is high) releases SDA and returns the slave to idle without disturbing the pointer.
- R3: Incoming bits are taken on the rising edge of SCL, most significant bit first. The slave changes its SDA drive only while SCL is low.
- R4: For every byte it accepts (a matching address, the sub-address, a data byte), the slave holds SDA low through the ninth SCL pulse and releases it after that pulse ends.
- R5: In a write transfer, the byte after the address loads the pointer. Each following byte produces one `reg_wr_en` pulse carrying that byte at the current pointer, and the pointer then advances by one. A STOP right after the sub-address leaves the pointer at the sub-address with no write.
- R6: A read transfer with no preceding sub-address returns the register at the current pointer and then advances the pointer.
- R7: A sub-address write followed by a repeated START and a read returns the register at that sub-address first.
- R8: While the master acknowledges, a read returns consecutive registers. After a byte that the master does not acknowledge, the slave releases SDA and sends nothing more until the next START.
- R9: The pointer wraps from its highest value (0xFF with 8-bit addressing) to 0, for both writes and reads.
- R10: Under reset, SDA is released, the pointer is 0 and neither strobe is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line as seen at the pad |
| sda_i | input | 1 | I2C data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_addr | output | ADDR_W | Byte pointer, the register being accessed |
| reg_wr_en | output | 1 | One-cycle write strobe for reg_addr |
| reg_wdata | output | 8 | Byte to write, valid with reg_wr_en |
| reg_rd_en | output | 1 | One-cycle strobe in which reg_rdata is captured |
| reg_rdata | input | 8 | Register contents at reg_addr, combinational |

## Verification
The bench checks that the pointer is shared between transfers: a current-address read straight after a write, after a rejected address and after a write that stopped at its sub-address. A design with separate read and write pointers, or one that loaded the pointer on a mismatched address, would return the wrong byte. Random and sequential reads are checked across the 0xFF-to-0 wrap, and bytes are written across the same wrap. A pointer that advanced on the write phase of a random read, or that failed to wrap, would skip or repeat a register. The bench also checks that the line is released after the master's final NACK and after a STOP. A slave that kept driving there would corrupt the master's STOP.

// File: rtl/i2c_reg_slave_pkg.sv
package i2c_reg_slave_pkg;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_DEVADDR,
    PH_DEVACK,
    PH_SUBADDR,
    PH_SUBACK,
    PH_WRBYTE,
    PH_WRACK,
    PH_RDBYTE,
    PH_RDACK,
    PH_IGNORE
  } phase_t;

  typedef struct packed {
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
    logic sda;
  } bus_ev_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
  import i2c_reg_slave_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    scl_i,
  input  logic    sda_i,
  output bus_ev_t ev
);
  localparam int LINES = 2;
  localparam int SCL_IDX = 1;
  localparam int SDA_IDX = 0;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] cur;
  logic [LINES-1:0] prev;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= '1;
      end else begin
        chain <= {chain[STAGES-2:0], raw[g]};
      end
    end
    assign cur[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '1;
    else        prev <= cur;
  end

  always_comb begin
    ev.scl_rise = cur[SCL_IDX] & ~prev[SCL_IDX];
    ev.scl_fall = ~cur[SCL_IDX] & prev[SCL_IDX];
    ev.start    = cur[SCL_IDX] & prev[SCL_IDX] & prev[SDA_IDX] & ~cur[SDA_IDX];
    ev.stop     = cur[SCL_IDX] & prev[SCL_IDX] & ~prev[SDA_IDX] & cur[SDA_IDX];
    ev.sda      = cur[SDA_IDX];
  end

endmodule

// File: rtl/i2c_ptr_unit.sv
module i2c_ptr_unit #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              inc,
  output logic [ADDR_W-1:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr <= '0;
    else if (load) ptr <= load_val;
    else if (inc)  ptr <= ptr + 1'b1;
  end
endmodule

// File: rtl/i2c_phase_ctrl.sv
module i2c_phase_ctrl
  import i2c_reg_slave_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1000011,
  parameter int         ADDR_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_ev_t           ev,
  input  logic [7:0]        reg_rdata,
  output logic              sda_oe,
  output logic              ptr_load,
  output logic [ADDR_W-1:0] ptr_val,
  output logic              ptr_inc,
  output logic              reg_wr_en,
  output logic [7:0]        reg_wdata,
  output logic              reg_rd_en
);
  localparam int         BYTE_BITS = 8;
  localparam logic [3:0] FULL_CNT  = 4'(BYTE_BITS);
  localparam logic [3:0] LAST_TX   = 4'(BYTE_BITS - 1);

  phase_t     ph;
  logic [7:0] sh;
  logic [7:0] tx;
  logic [3:0] cnt;
  logic       half;
  logic       rw;
  logic       nack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      sh        <= '0;
      tx        <= '0;
      cnt       <= '0;
      half      <= 1'b0;
      rw        <= 1'b0;
      nack      <= 1'b0;
      sda_oe    <= 1'b0;
      ptr_load  <= 1'b0;
      ptr_val   <= '0;
      ptr_inc   <= 1'b0;
      reg_wr_en <= 1'b0;
      reg_wdata <= '0;
      reg_rd_en <= 1'b0;
    end else begin
      ptr_load  <= 1'b0;
      ptr_inc   <= 1'b0;
      reg_wr_en <= 1'b0;
      reg_rd_en <= 1'b0;
      if (ev.stop) begin
        ph     <= PH_IDLE;
        sda_oe <= 1'b0;
      end else if (ev.start) begin
        ph     <= PH_DEVADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        unique case (ph)
          PH_DEVADDR, PH_SUBADDR, PH_WRBYTE: begin
            if (ev.scl_rise && cnt != FULL_CNT) begin
              sh  <= {sh[6:0], ev.sda};
              cnt <= cnt + 1'b1;
            end else if (ev.scl_fall && cnt == FULL_CNT) begin
              cnt  <= '0;
              half <= 1'b0;
              if (ph == PH_DEVADDR) begin
                if (sh[7:1] == DEV_ADDR) begin
                  rw     <= sh[0];
                  ph     <= PH_DEVACK;
                  sda_oe <= 1'b1;
                end else begin
                  ph <= PH_IGNORE;
                end
              end else if (ph == PH_SUBADDR) begin
                ptr_load <= 1'b1;
                ptr_val  <= sh[ADDR_W-1:0];
                ph       <= PH_SUBACK;
                sda_oe   <= 1'b1;
              end else begin
                reg_wr_en <= 1'b1;
                reg_wdata <= sh;
                ptr_inc   <= 1'b1;
                ph        <= PH_WRACK;
                sda_oe    <= 1'b1;
              end
            end
          end
          PH_DEVACK, PH_SUBACK, PH_WRACK: begin
            if (ev.scl_rise) begin
              half <= 1'b1;
            end else if (ev.scl_fall && half) begin
              half   <= 1'b0;
              cnt    <= '0;
              sda_oe <= 1'b0;
              if (ph == PH_DEVACK && rw) begin
                ph        <= PH_RDBYTE;
                tx        <= reg_rdata;
                sda_oe    <= ~reg_rdata[7];
                reg_rd_en <= 1'b1;
                ptr_inc   <= 1'b1;
              end else if (ph == PH_DEVACK) begin
                ph <= PH_SUBADDR;
              end else begin
                ph <= PH_WRBYTE;
              end
            end
          end
          PH_RDBYTE: begin
            if (ev.scl_fall) begin
              if (cnt == LAST_TX) begin
                ph     <= PH_RDACK;
                sda_oe <= 1'b0;
                half   <= 1'b0;
              end else begin
                tx     <= {tx[6:0], 1'b0};
                sda_oe <= ~tx[6];
                cnt    <= cnt + 1'b1;
              end
            end
          end
          PH_RDACK: begin
            if (ev.scl_rise) begin
              nack <= ev.sda;
              half <= 1'b1;
            end else if (ev.scl_fall && half) begin
              half <= 1'b0;
              cnt  <= '0;
              if (!nack) begin
                ph        <= PH_RDBYTE;
                tx        <= reg_rdata;
                sda_oe    <= ~reg_rdata[7];
                reg_rd_en <= 1'b1;
                ptr_inc   <= 1'b1;
              end else begin
                ph <= PH_IGNORE;
              end
            end
          end
          default: begin
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_reg_slave_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b1000011,
  parameter int         ADDR_W      = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_wr_en,
  output logic [7:0]        reg_wdata,
  output logic              reg_rd_en,
  input  logic [7:0]        reg_rdata
);
  bus_ev_t           bus_ev;
  logic              ptr_load;
  logic              ptr_inc;
  logic [ADDR_W-1:0] ptr_val;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .ev    (bus_ev)
  );

  i2c_phase_ctrl #(.DEV_ADDR(DEV_ADDR), .ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev        (bus_ev),
    .reg_rdata (reg_rdata),
    .sda_oe    (sda_oe),
    .ptr_load  (ptr_load),
    .ptr_val   (ptr_val),
    .ptr_inc   (ptr_inc),
    .reg_wr_en (reg_wr_en),
    .reg_wdata (reg_wdata),
    .reg_rd_en (reg_rd_en)
  );

  i2c_ptr_unit #(.ADDR_W(ADDR_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ptr_load),
    .load_val (ptr_val),
    .inc      (ptr_inc),
    .ptr      (reg_addr)
  );

endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic              stop_seen,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr_en,
  input logic              reg_rd_en
);
  // R3
  sda_change_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  // R2
  stop_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> !sda_oe);

  // R5
  write_advances_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> (reg_addr == ADDR_W'($past(reg_addr) + 1'b1)));

  // R6
  read_advances_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |=> (reg_addr == ADDR_W'($past(reg_addr) + 1'b1)));

  // R5
  single_write_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en);

  // R8
  no_mixed_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en && reg_rd_en));

  // R10
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!sda_oe && !reg_wr_en && !reg_rd_en);
    end
  end
endmodule

bind i2c_reg_slave i2c_reg_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_i     (scl_i),
  .sda_oe    (sda_oe),
  .stop_seen (bus_ev.stop),
  .reg_addr  (reg_addr),
  .reg_wr_en (reg_wr_en),
  .reg_rd_en (reg_rd_en)
);

// File: tb/test_i2c_reg_slave.sv
module test_i2c_reg_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_oe;
  logic       sda_line;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       reg_wr_en, reg_rd_en;
  logic [7:0] mem [256];

  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;
  string      cur_req = "R5";
  logic [15:0] exp_wr[$];
  logic [15:0] got_wr;
  logic [15:0] want_wr;

  assign sda_line  = sda_m & ~sda_oe;
  assign reg_rdata = mem[reg_addr];

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_reg_slave i_i2c_reg_slave (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_m),
    .sda_i     (sda_line),
    .sda_oe    (sda_oe),
    .reg_addr  (reg_addr),
    .reg_wr_en (reg_wr_en),
    .reg_wdata (reg_wdata),
    .reg_rd_en (reg_rd_en),
    .reg_rdata (reg_rdata)
  );

  // register file model, preset to i ^ 0xA5
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'hA5;
    end else if (reg_wr_en) begin
      mem[reg_addr] <= reg_wdata;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor for register writes
  always @(negedge clk) begin
    if (rst_n && reg_wr_en) begin
      got_wr = {reg_addr, reg_wdata};
      if (exp_wr.size() == 0) begin
        chk(1'b0, cur_req, "unexpected write", int'(got_wr), 0);
      end else begin
        want_wr = exp_wr.pop_front();
        chk(got_wr == want_wr, cur_req, "write addr/data", int'(got_wr), int'(want_wr));
      end
    end
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold(Q);
    scl_m = 1'b1; hold(Q);
    sda_m = 1'b0; hold(Q);
    scl_m = 1'b0; hold(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold(Q);
    scl_m = 1'b1; hold(Q);
    sda_m = 1'b1; hold(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hold(Q);
      scl_m = 1'b1; hold(2*Q);
      scl_m = 1'b0; hold(Q);
    end
    sda_m = 1'b1; hold(Q);
    scl_m = 1'b1; hold(Q);
    acked = (sda_line == 1'b0);
    hold(Q);
    scl_m = 1'b0; hold(Q);
  endtask

  task automatic recv_byte(input bit send_nack, output logic [7:0] b);
    logic s1;
    logic s2;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold(Q);
      scl_m = 1'b1; hold(Q);
      s1 = sda_line; hold(Q - 1);
      s2 = sda_line; hold(1);
      chk(s1 == s2, "R3", "SDA moved while SCL high", int'(s2), int'(s1));
      b[i] = s1;
      scl_m = 1'b0;
    end
    hold(Q);
    sda_m = send_nack; hold(Q);
    scl_m = 1'b1; hold(2*Q);
    scl_m = 1'b0; hold(Q);
    sda_m = 1'b1;
  endtask

  task automatic wr_seq(input logic [7:0] sub, input logic [7:0] d0,
                        input logic [7:0] d1, input string req);
    bit a;
    bus_start();
    send_byte(8'h86, a); chk(a, "R1", "address ack (write)", int'(a), 1);
    send_byte(sub, a);   chk(a, "R4", "sub-address ack", int'(a), 1);
    exp_wr.push_back({sub, d0});
    send_byte(d0, a);    chk(a, req, "data ack 0", int'(a), 1);
    exp_wr.push_back({sub + 8'd1, d1});
    send_byte(d1, a);    chk(a, req, "data ack 1", int'(a), 1);
    bus_stop();
  endtask

  initial begin
    bit         a;
    logic [7:0] d;

    hold(3);
    // R10: reset state
    chk(sda_oe == 1'b0, "R10", "sda_oe in reset", int'(sda_oe), 0);
    chk(reg_addr == 8'h00, "R10", "pointer in reset", int'(reg_addr), 0);
    chk(!reg_wr_en && !reg_rd_en, "R10", "strobes in reset", int'({reg_wr_en, reg_rd_en}), 0);
    rst_n = 1'b1;
    hold(5);

    // R5: three-byte write from 0x10
    cur_req = "R5";
    bus_start();
    send_byte(8'h86, a); chk(a, "R1", "address ack", int'(a), 1);
    send_byte(8'h10, a); chk(a, "R4", "sub ack", int'(a), 1);
    exp_wr.push_back(16'h1011); send_byte(8'h11, a); chk(a, "R4", "data ack", int'(a), 1);
    exp_wr.push_back(16'h1122); send_byte(8'h22, a); chk(a, "R5", "data ack", int'(a), 1);
    exp_wr.push_back(16'h1233); send_byte(8'h33, a); chk(a, "R5", "data ack", int'(a), 1);
    bus_stop();
    chk(reg_addr == 8'h13, "R5", "pointer after write", int'(reg_addr), 8'h13);
    chk(sda_oe == 1'b0, "R2", "released after STOP", int'(sda_oe), 0);

    // R6: current-address read continues at 0x13
    bus_start();
    send_byte(8'h87, a); chk(a, "R1", "address ack (read)", int'(a), 1);
    recv_byte(1'b1, d);  chk(d == 8'hB6, "R6", "current read byte", int'(d), 8'hB6);
    bus_stop();
    chk(reg_addr == 8'h14, "R6", "pointer after read", int'(reg_addr), 8'h14);

    // R7 + R8: random read at 0x11, sequential three bytes
    bus_start();
    send_byte(8'h86, a); chk(a, "R7", "address ack", int'(a), 1);
    send_byte(8'h11, a); chk(a, "R7", "sub ack", int'(a), 1);
    bus_start();
    send_byte(8'h87, a); chk(a, "R7", "read address ack after restart", int'(a), 1);
    recv_byte(1'b0, d);  chk(d == 8'h22, "R7", "random read first byte", int'(d), 8'h22);
    recv_byte(1'b0, d);  chk(d == 8'h33, "R8", "sequential byte 2", int'(d), 8'h33);
    recv_byte(1'b1, d);  chk(d == 8'hB6, "R8", "sequential byte 3", int'(d), 8'hB6);
    hold(2*Q);
    chk(sda_oe == 1'b0, "R8", "released after NACK", int'(sda_oe), 0);
    bus_stop();

    // R1: non-matching address (1000010) is ignored
    cur_req = "R1";
    bus_start();
    send_byte(8'h84, a); chk(!a, "R1", "no ack on wrong address", int'(a), 0);
    send_byte(8'h05, a); chk(!a, "R1", "no ack after wrong address", int'(a), 0);
    send_byte(8'h77, a); chk(!a, "R1", "no ack on data", int'(a), 0);
    bus_stop();
    chk(reg_addr == 8'h14, "R1", "pointer untouched", int'(reg_addr), 8'h14);
    bus_start();
    send_byte(8'h87, a);
    recv_byte(1'b1, d);  chk(d == 8'hB1, "R1", "read after ignored transfer", int'(d), 8'hB1);
    bus_stop();

    // R9: write across the wrap
    wr_seq(8'hFF, 8'hAB, 8'hCD, "R9");
    chk(reg_addr == 8'h01, "R9", "pointer wrapped after write", int'(reg_addr), 1);

    // R9: sequential read across the wrap
    bus_start();
    send_byte(8'h86, a);
    send_byte(8'hFE, a);
    bus_start();
    send_byte(8'h87, a);
    recv_byte(1'b0, d);  chk(d == 8'h5B, "R9", "read 0xFE", int'(d), 8'h5B);
    recv_byte(1'b0, d);  chk(d == 8'hAB, "R9", "read 0xFF", int'(d), 8'hAB);
    recv_byte(1'b1, d);  chk(d == 8'hCD, "R9", "read 0x00 after wrap", int'(d), 8'hCD);
    bus_stop();
    chk(reg_addr == 8'h01, "R9", "pointer wrapped after read", int'(reg_addr), 1);

    // R5 + R2: STOP right after the sub-address only moves the pointer
    cur_req = "R5";
    bus_start();
    send_byte(8'h86, a);
    send_byte(8'h40, a); chk(a, "R5", "sub ack", int'(a), 1);
    bus_stop();
    chk(reg_addr == 8'h40, "R5", "pointer loaded, no write", int'(reg_addr), 8'h40);
    bus_start();
    send_byte(8'h87, a);
    recv_byte(1'b1, d);  chk(d == 8'hE5, "R2", "read after early STOP", int'(d), 8'hE5);
    bus_stop();

    chk(exp_wr.size() == 0, "R5", "writes outstanding", exp_wr.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule